// File: doc/BRIEF.md
# Programmable I/O Bus Clock Generator

This block holds the control word for an external I/O bus and produces that bus's clock. A host reads and writes one 32-bit control word over a simple register port. The word carries an address-space select, a wait-state count, a bus enable and a clock divider setting. Only the address-space select, the wait-state count and the enable leave the block as plain outputs for the bus logic.

A strap pin sets the bus clock source. The block reads the strap once, on the first clock edge after reset. With the strap low, the bus clock pin is an input: the external clock passes straight through and the pin's output enable stays low. With the strap high, the block divides the system clock, drives the result onto the bus clock output and raises the output enable.

The divider runs from a counter and changes only on period boundaries, so it never emits a shortened or glitched pulse. A divider setting of zero is treated as divide-by-two and raises an error flag.

Top module: `iobus_clk_gen`

## Requirements
- R1: The control word has these fields: address-space select in bits 31:26, wait-state count in bits 10:8, bus enable in bit 7 and divider setting N in bits 4:0. Writes to bits 25:11 and 6:5 are discarded, and those bits always read as zero.
- R2: After reset the word reads 0x0000001F. This means N=31, bus disabled, zero wait states and address space 0. The outputs bus_en_o, wait_states_o and addr_space_o show the same reset values.
- R3: A read strobe in one cycle returns the word on rdata_o in the next cycle. When a read and a write fall in the same cycle, the read returns the value held before the write.
- R4: With the internal source selected and N not zero, each bus clock period lasts N+1 system clock cycles. The high phase lasts floor((N+1)/2) cycles and the low phase lasts the rest.
- R5: With N=0 the divider runs as divide-by-2 (one cycle high, one cycle low) and div_err_o is 1. Writing a nonzero N clears div_err_o in the next cycle.
- R6: A newly written N is applied only at the next rising edge of the divided clock. The period already in progress completes with its old high and low lengths.
- R7: While the bus enable bit is 0, the divided clock stays low. A write that sets the enable takes effect at one clock edge. The divided clock then rises at the following edge and starts a fresh period with its high phase.
- R8: With the strap latched at 1, bus_clk_oe_o is 1 and bus_clk_o is the divided clock. With the strap latched at 0, bus_clk_oe_o is 0 and bus_clk_o follows ext_clk_i.
- R9: The strap is sampled only on the first clock edge after reset. Changes on strap_int_clk_i after that edge have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_int_clk_i | input | 1 | Boot strap: 1 selects the internal divided clock |
| ext_clk_i | input | 1 | External bus clock, used when the strap is 0 |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid in the cycle after rd_en_i |
| bus_clk_o | output | 1 | Bus clock |
| bus_clk_oe_o | output | 1 | Output enable for the bus clock pin |
| bus_en_o | output | 1 | Bus enable field |
| wait_states_o | output | 3 | Wait-state count field |
| addr_space_o | output | 6 | Address-space select field |
| div_err_o | output | 1 | Divider setting is zero |

## Verification
The hardest case is a divider change that lands in the middle of a running period. The bench waits until it sees a rising edge of the bus clock. It then writes a new N in the very next cycle. It measures the phases that remain of the old period before it measures the first period at the new rate. Strap handling requires a second reset, with the strap held at a different level. The strap is toggled only after the first edge has passed, to show that the latched source does not change.

// File: rtl/iobus_clk_pkg.sv
package iobus_clk_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned AS_LSB  = 26;
  localparam int unsigned AS_W    = 6;
  localparam int unsigned WS_LSB  = 8;
  localparam int unsigned WS_W    = 3;
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned DIV_LSB = 0;
  localparam int unsigned DIV_W   = 5;
  localparam logic [DIV_W-1:0] DIV_RST = '1;

  typedef struct packed {
    logic [AS_W-1:0]  addr_space;
    logic [WS_W-1:0]  wait_st;
    logic             bus_en;
    logic [DIV_W-1:0] div;
  } ctl_t;

  function automatic logic [REG_W-1:0] ctl_pack(ctl_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[AS_LSB +: AS_W]   = c.addr_space;
    r[WS_LSB +: WS_W]   = c.wait_st;
    r[EN_BIT]           = c.bus_en;
    r[DIV_LSB +: DIV_W] = c.div;
    return r;
  endfunction

  function automatic ctl_t ctl_unpack(logic [REG_W-1:0] r);
    ctl_t c;
    c.addr_space = r[AS_LSB +: AS_W];
    c.wait_st    = r[WS_LSB +: WS_W];
    c.bus_en     = r[EN_BIT];
    c.div        = r[DIV_LSB +: DIV_W];
    return c;
  endfunction
endpackage

// File: rtl/iobus_ctl_reg.sv
module iobus_ctl_reg
  import iobus_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rdata_o,
  output ctl_t             ctl_o
);
  ctl_t             ctl_q;
  logic [REG_W-1:0] rdata_q;
  logic             unused_wbits;

  // reserved write bits are dropped
  assign unused_wbits = ^{wdata_i[AS_LSB-1:WS_LSB+WS_W], wdata_i[EN_BIT-1:DIV_LSB+DIV_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q.addr_space <= '0;
      ctl_q.wait_st    <= '0;
      ctl_q.bus_en     <= 1'b0;
      ctl_q.div        <= DIV_RST;
    end else if (wr_en_i) begin
      ctl_q <= ctl_unpack(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= ctl_pack(ctl_q);
  end

  assign rdata_o = rdata_q;
  assign ctl_o   = ctl_q;
endmodule

// File: rtl/iobus_strap_latch.sv
module iobus_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic int_sel_o
);
  logic booted_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      booted_q <= 1'b0;
      sel_q    <= 1'b0;
    end else if (!booted_q) begin
      booted_q <= 1'b1;
      sel_q    <= strap_i;
    end
  end

  assign int_sel_o = sel_q;
endmodule

// File: rtl/iobus_clk_div.sv
module iobus_clk_div #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o,
  output logic             err_o
);
  localparam int unsigned HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, act_q, cnt_nxt, div_eff;
  logic [HW-1:0]    half;
  logic             run_q, clk_q;

  assign err_o   = (div_i == '0);
  assign div_eff = err_o ? DIV_W'(1) : div_i;
  assign half    = ({1'b0, act_q} + HW'(1)) >> 1;
  assign cnt_nxt = cnt_q + DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '1;
      run_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (!run_i) begin
        cnt_q <= '0;
        clk_q <= 1'b0;
      end else if (!run_q || cnt_q == act_q) begin
        // period boundary: reload setting, start high phase
        cnt_q <= '0;
        act_q <= div_eff;
        clk_q <= 1'b1;
      end else begin
        cnt_q <= cnt_nxt;
        clk_q <= ({1'b0, cnt_nxt} < half);
      end
    end
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/iobus_clk_gen.sv
module iobus_clk_gen
  import iobus_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_int_clk_i,
  input  logic             ext_clk_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             bus_clk_o,
  output logic             bus_clk_oe_o,
  output logic             bus_en_o,
  output logic [WS_W-1:0]  wait_states_o,
  output logic [AS_W-1:0]  addr_space_o,
  output logic             div_err_o
);
  ctl_t ctl;
  logic int_sel, div_clk;

  iobus_ctl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rd_en_i (rd_en_i),
    .rdata_o (rdata_o),
    .ctl_o   (ctl)
  );

  iobus_strap_latch u_strap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_int_clk_i),
    .int_sel_o (int_sel)
  );

  iobus_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctl.bus_en & int_sel),
    .div_i  (ctl.div),
    .clk_o  (div_clk),
    .err_o  (div_err_o)
  );

  assign bus_clk_o     = int_sel ? div_clk : ext_clk_i;
  assign bus_clk_oe_o  = int_sel;
  assign bus_en_o      = ctl.bus_en;
  assign wait_states_o = ctl.wait_st;
  assign addr_space_o  = ctl.addr_space;
endmodule

// File: rtl/iobus_clk_gen_chk.sv
module iobus_clk_gen_chk
  import iobus_clk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [DIV_W-1:0] wdiv_i,
  input logic             rd_en_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             bus_clk_o,
  input logic             bus_clk_oe_o,
  input logic             bus_en_o,
  input logic [WS_W-1:0]  wait_states_o,
  input logic [AS_W-1:0]  addr_space_o,
  input logic             div_err_o
);
  logic       seen_q;
  logic [6:0] hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      hi_run_q <= '0;
    end else begin
      seen_q   <= 1'b1;
      hi_run_q <= (bus_clk_o && bus_clk_oe_o) ?
                  ((hi_run_q == 7'h7f) ? hi_run_q : hi_run_q + 7'd1) : 7'd0;
    end
  end

  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[25:11] == '0) && (rdata_o[6:5] == '0));

  // R3
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rdata_o[10:8] == $past(wait_states_o)) && (rdata_o[7] == $past(bus_en_o))
                && (rdata_o[31:26] == $past(addr_space_o)));

  // R4
  hi_phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run_q <= 7'd16);

  // R5
  div_zero_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdiv_i == '0) |=> div_err_o);

  // R5
  div_err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdiv_i != '0) |=> !div_err_o);

  // R7
  disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_en_o && bus_clk_oe_o) |=> !bus_clk_o);

  // R9
  strap_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> $stable(bus_clk_oe_o));
endmodule

bind iobus_clk_gen iobus_clk_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wdiv_i        (wdata_i[iobus_clk_pkg::DIV_LSB +: iobus_clk_pkg::DIV_W]),
  .rd_en_i       (rd_en_i),
  .rdata_o       (rdata_o),
  .bus_clk_o     (bus_clk_o),
  .bus_clk_oe_o  (bus_clk_oe_o),
  .bus_en_o      (bus_en_o),
  .wait_states_o (wait_states_o),
  .addr_space_o  (addr_space_o),
  .div_err_o     (div_err_o)
);

// File: tb/iobus_clk_gen_test.sv
module iobus_clk_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap_int_clk_i = 1'b1;
  logic        ext_clk_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic        bus_clk_o, bus_clk_oe_o, bus_en_o, div_err_o;
  logic [2:0]  wait_states_o;
  logic [5:0]  addr_space_o;

  int n_tot = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  iobus_clk_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_int_clk_i(strap_int_clk_i), .ext_clk_i(ext_clk_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .bus_clk_o(bus_clk_o), .bus_clk_oe_o(bus_clk_oe_o), .bus_en_o(bus_en_o),
    .wait_states_o(wait_states_o), .addr_space_o(addr_space_o), .div_err_o(div_err_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0;
    strap_int_clk_i = strap;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic reg_wr(logic [31:0] d);
    wr_en_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(output logic [31:0] d);
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic measure(output int hi, output int lo);
    int guard;
    logic prev;
    guard = 0;
    prev = bus_clk_o;
    @(negedge clk_i);
    while (!(!prev && bus_clk_o) && guard < 300) begin
      prev = bus_clk_o; @(negedge clk_i); guard++;
    end
    hi = 0;
    while (bus_clk_o && hi < 100) begin hi++; @(negedge clk_i); end
    lo = 0;
    while (!bus_clk_o && lo < 100) begin lo++; @(negedge clk_i); end
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R2 bus_en_o", 32'(bus_en_o), 32'd0);
    chk("R2 wait_states_o", 32'(wait_states_o), 32'd0);
    chk("R2 addr_space_o", 32'(addr_space_o), 32'd0);
    chk("R2 bus_clk_o low", 32'(bus_clk_o), 32'd0);
    reg_rd(d);
    chk("R2 reset word", d, 32'h0000_001F);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    reg_wr(32'hFFFF_FF7D);
    reg_rd(d);
    chk("R1 reserved bits dropped", d, 32'hFC00_071D);
    chk("R1 addr_space_o", 32'(addr_space_o), 32'h3F);
    chk("R1 wait_states_o", 32'(wait_states_o), 32'h7);
    chk("R1 bus_en_o off", 32'(bus_en_o), 32'd0);
    reg_wr(32'h0000_0083);
    chk("R1 bus_en_o on", 32'(bus_en_o), 32'd1);
    reg_wr(32'h0000_001F);
  endtask

  task automatic t_rd_during_wr();
    logic [31:0] d;
    reg_wr(32'h0000_0203);
    rd_en_i = 1'b1; wr_en_i = 1'b1; wdata_i = 32'h0000_0505;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    chk("R3 read returns old word", rdata_o, 32'h0000_0203);
    reg_rd(d);
    chk("R3 new word visible", d, 32'h0000_0505);
  endtask

  task automatic t_period(int n);
    int hi, lo, ehi;
    reg_wr(32'h80 | 32'(n));
    measure(hi, lo);
    measure(hi, lo);
    ehi = (n + 1) / 2;
    chk($sformatf("R4 high N=%0d", n), 32'(hi), 32'(ehi));
    chk($sformatf("R4 low N=%0d", n), 32'(lo), 32'(n + 1 - ehi));
  endtask

  task automatic t_div_zero();
    int hi, lo;
    reg_wr(32'h0000_0080);
    chk("R5 err flag set", 32'(div_err_o), 32'd1);
    measure(hi, lo);
    measure(hi, lo);
    chk("R5 high N=0", 32'(hi), 32'd1);
    chk("R5 low N=0", 32'(lo), 32'd1);
    reg_wr(32'h0000_0083);
    chk("R5 err flag cleared", 32'(div_err_o), 32'd0);
  endtask

  task automatic t_change();
    int hi, lo, guard;
    logic prev;
    reg_wr(32'h0000_0087);
    measure(hi, lo);
    guard = 0;
    prev = bus_clk_o;
    @(negedge clk_i);
    while (!(!prev && bus_clk_o) && guard < 100) begin
      prev = bus_clk_o; @(negedge clk_i); guard++;
    end
    hi = 1;
    wr_en_i = 1'b1; wdata_i = 32'h0000_0083;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    while (bus_clk_o && hi < 100) begin hi++; @(negedge clk_i); end
    lo = 0;
    while (!bus_clk_o && lo < 100) begin lo++; @(negedge clk_i); end
    chk("R6 old high kept", 32'(hi), 32'd4);
    chk("R6 old low kept", 32'(lo), 32'd4);
    hi = 0;
    while (bus_clk_o && hi < 100) begin hi++; @(negedge clk_i); end
    lo = 0;
    while (!bus_clk_o && lo < 100) begin lo++; @(negedge clk_i); end
    chk("R6 new high", 32'(hi), 32'd2);
    chk("R6 new low", 32'(lo), 32'd2);
  endtask

  task automatic t_enable();
    int highs;
    reg_wr(32'h0000_0005);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (bus_clk_o) highs++;
    end
    chk("R7 disabled stays low", 32'(highs), 32'd0);
    wr_en_i = 1'b1; wdata_i = 32'h0000_0085;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R7 low right after enable write", 32'(bus_clk_o), 32'd0);
    @(negedge clk_i);
    chk("R7 rises next edge", 32'(bus_clk_o), 32'd1);
    repeat (2) @(negedge clk_i);
    chk("R7 high phase from zero", 32'(bus_clk_o), 32'd1);
    @(negedge clk_i);
    chk("R7 then low", 32'(bus_clk_o), 32'd0);
  endtask

  task automatic t_strap_ext();
    do_reset(1'b0);
    chk("R8 oe low with ext source", 32'(bus_clk_oe_o), 32'd0);
    reg_wr(32'h0000_0083);
    ext_clk_i = 1'b1; #1;
    chk("R8 follows ext high", 32'(bus_clk_o), 32'd1);
    ext_clk_i = 1'b0; #1;
    chk("R8 follows ext low", 32'(bus_clk_o), 32'd0);
    strap_int_clk_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R9 late strap ignored", 32'(bus_clk_oe_o), 32'd0);
    ext_clk_i = 1'b1; #1;
    chk("R9 still ext source", 32'(bus_clk_o), 32'd1);
    ext_clk_i = 1'b0;
    do_reset(1'b1);
    chk("R8 oe high with int source", 32'(bus_clk_oe_o), 32'd1);
    strap_int_clk_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R9 oe held after strap drop", 32'(bus_clk_oe_o), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tot++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    t_reset_state();
    t_fields();
    t_rd_during_wr();
    t_period(1);
    t_period(2);
    t_period(3);
    t_period(8);
    t_period(31);
    t_div_zero();
    t_change();
    t_enable();
    t_strap_ext();
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule